// File: doc/BRIEF.md
# Chip-Select Bus Wait-State Controller

This block stretches external bus accesses by a programmable number of wait cycles. It serves two chip-select spaces. A separate setting applies when a DMA transfer uses single-address mode. A bus master raises a start strobe along with a space index and a DMA single-address flag. The controller counts out the programmed waits. When external waits are enabled, it then keeps the cycle open for as long as the device pulls the active-low wait line low. A one-clock ready pulse closes the access.

Two 16-bit registers hold the settings. The space register holds one 4-bit wait field per chip-select space. The DMA register holds a 4-bit chip-select wait field and a 2-bit DRAM cycle field. The DRAM cycle field is passed straight out to the DRAM timing logic. There are two kinds of reset. An asynchronous power-on reset initialises both registers. A synchronous manual reset restores only the space register and abandons any access in flight. The DMA register keeps its contents through a manual reset.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After power-on reset the space register reads 0x00FF, the DMA register reads 0x000F, `dram_cyc_o` is 0 and `ready_o` is low.
- R2: In the space register, bits 3:0 hold the wait count of space 0 and bits 7:4 hold the wait count of space 1. With a count N and the wait line high, `ready_o` is high in the clock cycle that begins N rising edges after the edge that samples `acc_start_i`.
- R3: A wait count of 0 gives ready in the first cycle after the start edge. For such an access `ext_wait_ni` is ignored, even if it is held low.
- R4: A nonzero count enables the wait line. After the N waits, each cycle in which `ext_wait_ni` is low delays ready by one clock. A low level during the counted waits has no effect.
- R5: While `dma_sa_i` is 1, the wait count comes from DMA register bits 3:0, whatever value `acc_space_i` has.
- R6: DMA register bits 5:4 are readable and writable and drive `dram_cyc_o`. Bits 15:6 of the DMA register and bits 15:8 of the space register always read 0.
- R7: A manual reset (`mrst_i` high at a clock edge) returns the space register to 0x00FF and ends any access without a ready pulse. It leaves the DMA register unchanged.
- R8: `ready_o` is high for exactly one clock per access. A start strobe seen while an access is in progress is ignored.
- R9: A register write during an access does not change that access's length. The new value applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| mrst_i | input | 1 | Synchronous manual reset, active high |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 space register, 1 DMA register |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| acc_start_i | input | 1 | Access start strobe |
| acc_space_i | input | 1 | Chip-select space index |
| dma_sa_i | input | 1 | DMA single-address transfer flag |
| ext_wait_ni | input | 1 | External wait request, active low |
| ready_o | output | 1 | One-clock end-of-access pulse |
| dram_cyc_o | output | 2 | DRAM cycle setting from the DMA register |

## Verification
The embedded properties check the following on every clock:
- the wait counter steps down by one per cycle and is never reloaded mid-access;
- ready never appears while waits remain;
- a zero-count start is followed by ready on the next cycle;
- ready never lasts two cycles, and an access ends only through ready;
- a manual reset restores the space register and leaves the DMA register alone.

The directed scenarios show the remaining behaviour:
- the exact latency for each field position, including the DMA source;
- how a late release of the wait line stretches the cycle;
- reserved read-back bits;
- ignored start strobes;
- the effect of writes and manual reset during an access.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;
  localparam int unsigned DATA_W_DEF    = 16;
  localparam int unsigned WAIT_W_DEF    = 4;
  localparam int unsigned DRAM_W_DEF    = 2;
  localparam int unsigned NUM_SPACE_DEF = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cs_wait_regs.sv
module cs_wait_regs #(
  parameter int unsigned DATA_W    = cs_wait_pkg::DATA_W_DEF,
  parameter int unsigned WAIT_W    = cs_wait_pkg::WAIT_W_DEF,
  parameter int unsigned DRAM_W    = cs_wait_pkg::DRAM_W_DEF,
  parameter int unsigned NUM_SPACE = cs_wait_pkg::NUM_SPACE_DEF
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               mrst_i,
  input  logic                               we_i,
  input  logic                               sel_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W-1:0]                  rdata_o,
  output logic [NUM_SPACE-1:0][WAIT_W-1:0]   space_wait_o,
  output logic [WAIT_W-1:0]                  dma_wait_o,
  output logic [DRAM_W-1:0]                  dram_cyc_o
);
  localparam int unsigned SPC_BITS = NUM_SPACE * WAIT_W;
  localparam int unsigned DMA_BITS = DRAM_W + WAIT_W;
  localparam logic [DMA_BITS-1:0] DMA_RST = {{DRAM_W{1'b0}}, {WAIT_W{1'b1}}};

  logic [SPC_BITS-1:0] space_q;
  logic [DMA_BITS-1:0] dma_q;

  // space register: power-on and manual reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      space_q <= '1;
    end else if (mrst_i) begin
      space_q <= '1;
    end else if (we_i && !sel_i) begin
      space_q <= wdata_i[SPC_BITS-1:0];
    end
  end

  // DMA register: power-on reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= DMA_RST;
    end else if (we_i && sel_i && !mrst_i) begin
      dma_q <= wdata_i[DMA_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SPACE; g++) begin : g_field
    assign space_wait_o[g] = space_q[g*WAIT_W +: WAIT_W];
  end

  assign dma_wait_o = dma_q[WAIT_W-1:0];
  assign dram_cyc_o = dma_q[DMA_BITS-1:WAIT_W];

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o[DMA_BITS-1:0] = dma_q;
    else       rdata_o[SPC_BITS-1:0] = space_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R7
  p_mrst_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (space_q == '1));
  // R7
  p_mrst_dma_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> $stable(dma_q));
endmodule

// File: rtl/cs_wait_sel.sv
module cs_wait_sel #(
  parameter int unsigned WAIT_W    = cs_wait_pkg::WAIT_W_DEF,
  parameter int unsigned NUM_SPACE = cs_wait_pkg::NUM_SPACE_DEF,
  parameter int unsigned IDX_W     = $clog2(NUM_SPACE)
) (
  input  logic [NUM_SPACE-1:0][WAIT_W-1:0] space_wait_i,
  input  logic [WAIT_W-1:0]                dma_wait_i,
  input  logic [IDX_W-1:0]                 space_i,
  input  logic                             dma_sa_i,
  output logic [WAIT_W-1:0]                count_o
);
  always_comb begin
    count_o = '0;
    if (dma_sa_i) begin
      count_o = dma_wait_i;
    end else begin
      for (int i = 0; i < NUM_SPACE; i++) begin
        if (space_i == IDX_W'(i)) count_o = space_wait_i[i];
      end
    end
  end
endmodule

// File: rtl/cs_wait_seq.sv
module cs_wait_seq #(
  parameter int unsigned WAIT_W = cs_wait_pkg::WAIT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] load_cnt_i,
  input  logic              ext_wait_ni,
  output logic              ready_o
);
  import cs_wait_pkg::*;

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  seq_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              ext_en_q;
  logic              busy;
  logic              cnt_done;

  assign busy     = (state_q == SEQ_BUSY);
  assign cnt_done = (cnt_q == '0);
  assign ready_o  = busy && cnt_done && (!ext_en_q || ext_wait_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      ext_en_q <= 1'b0;
    end else if (mrst_i) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      ext_en_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q  <= SEQ_BUSY;
            cnt_q    <= load_cnt_i;
            ext_en_q <= (load_cnt_i != '0);
          end
        end
        SEQ_BUSY: begin
          if (!cnt_done)    cnt_q   <= cnt_q - ONE;
          else if (ready_o) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R2, R9: one step per cycle, no reload mid-access
  p_count_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || mrst_i)
    (busy && !cnt_done) |=> (busy && cnt_q == $past(cnt_q) - ONE));
  p_zero_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || mrst_i)
    (!busy && start_i && load_cnt_i == '0) |=> ready_o);
  p_no_early_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_done |-> !ready_o);
  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || mrst_i)
    ready_o |=> !ready_o);
  p_end_by_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || mrst_i)
    (busy && !ready_o) |=> busy);
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl #(
  parameter int unsigned DATA_W    = cs_wait_pkg::DATA_W_DEF,
  parameter int unsigned WAIT_W    = cs_wait_pkg::WAIT_W_DEF,
  parameter int unsigned DRAM_W    = cs_wait_pkg::DRAM_W_DEF,
  parameter int unsigned NUM_SPACE = cs_wait_pkg::NUM_SPACE_DEF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mrst_i,
  input  logic                         reg_we_i,
  input  logic                         reg_sel_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  input  logic                         acc_start_i,
  input  logic [$clog2(NUM_SPACE)-1:0] acc_space_i,
  input  logic                         dma_sa_i,
  input  logic                         ext_wait_ni,
  output logic                         ready_o,
  output logic [DRAM_W-1:0]            dram_cyc_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SPACE);

  logic [NUM_SPACE-1:0][WAIT_W-1:0] space_wait;
  logic [WAIT_W-1:0]                dma_wait;
  logic [WAIT_W-1:0]                load_cnt;

  cs_wait_regs #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W), .DRAM_W(DRAM_W), .NUM_SPACE(NUM_SPACE)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mrst_i      (mrst_i),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .space_wait_o(space_wait),
    .dma_wait_o  (dma_wait),
    .dram_cyc_o  (dram_cyc_o)
  );

  cs_wait_sel #(
    .WAIT_W(WAIT_W), .NUM_SPACE(NUM_SPACE), .IDX_W(IDX_W)
  ) u_sel (
    .space_wait_i(space_wait),
    .dma_wait_i  (dma_wait),
    .space_i     (acc_space_i),
    .dma_sa_i    (dma_sa_i),
    .count_o     (load_cnt)
  );

  cs_wait_seq #(
    .WAIT_W(WAIT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mrst_i     (mrst_i),
    .start_i    (acc_start_i),
    .load_cnt_i (load_cnt),
    .ext_wait_ni(ext_wait_ni),
    .ready_o    (ready_o)
  );
endmodule

// File: tb/cs_wait_ctrl_bench.sv
module cs_wait_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mrst_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        acc_start_i = 1'b0;
  logic [0:0]  acc_space_i = '0;
  logic        dma_sa_i = 1'b0;
  logic        ext_wait_ni = 1'b1;
  logic        ready_o;
  logic [1:0]  dram_cyc_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  cs_wait_ctrl u_cs_wait_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mrst_i(mrst_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .acc_start_i(acc_start_i), .acc_space_i(acc_space_i),
    .dma_sa_i(dma_sa_i), .ext_wait_ni(ext_wait_ni), .ready_o(ready_o),
    .dram_cyc_o(dram_cyc_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [15:0] d);
    @(negedge clk_i);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  // act: 0 none, 1 extra start, 2 write space reg, 3 manual reset
  task automatic run_access(input logic sp, input logic dma, input int rel_k,
                            input int act_k, input int act, input logic [15:0] act_d,
                            output int lat, output int extra);
    lat = -1; extra = 0;
    @(negedge clk_i);
    acc_space_i = sp; dma_sa_i = dma;
    ext_wait_ni = (rel_k > 0) ? 1'b0 : 1'b1;
    acc_start_i = 1'b1;
    @(negedge clk_i);
    acc_start_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (k == rel_k) ext_wait_ni = 1'b1;
      if (k == act_k) begin
        case (act)
          1: acc_start_i = 1'b1;
          2: begin reg_we_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = act_d; end
          3: mrst_i = 1'b1;
          default: ;
        endcase
      end
      #1;
      if (ready_o) begin
        if (lat < 0) lat = k;
        else extra++;
      end
      @(negedge clk_i);
      acc_start_i = 1'b0; reg_we_i = 1'b0; mrst_i = 1'b0;
    end
    ext_wait_ni = 1'b1; dma_sa_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #1;
    check(ready_o == 1'b0, "R1 ready after reset", int'(ready_o), 0);
    check(dram_cyc_o == 2'd0, "R1 dram_cyc after reset", int'(dram_cyc_o), 0);
    read_reg(1'b0, d);
    check(d == 16'h00FF, "R1 space reg reset", int'(d), 'h00FF);
    read_reg(1'b1, d);
    check(d == 16'h000F, "R1 dma reg reset", int'(d), 'h000F);
  endtask

  task automatic t_space_latency();
    int lat, ex;
    logic [15:0] d;
    write_reg(1'b0, 16'hAB52);
    read_reg(1'b0, d);
    check(d == 16'h0052, "R6 space reg upper bits zero", int'(d), 'h0052);
    run_access(1'b0, 1'b0, 0, -1, 0, '0, lat, ex);
    check(lat == 2, "R2 space0 latency", lat, 2);
    check(ex == 0, "R8 single ready pulse", ex, 0);
    run_access(1'b1, 1'b0, 0, -1, 0, '0, lat, ex);
    check(lat == 5, "R2 space1 latency", lat, 5);
  endtask

  task automatic t_zero_count();
    int lat, ex;
    write_reg(1'b0, 16'h0030);
    run_access(1'b0, 1'b0, 30, -1, 0, '0, lat, ex);
    check(lat == 0, "R3 zero count ignores wait line", lat, 0);
    check(ex == 0, "R3 no extra ready", ex, 0);
  endtask

  task automatic t_ext_wait();
    int lat, ex;
    run_access(1'b1, 1'b0, 7, -1, 0, '0, lat, ex);
    check(lat == 7, "R4 wait line stretches cycle", lat, 7);
    check(ex == 0, "R8 one pulse after stretch", ex, 0);
    write_reg(1'b0, 16'h0050);
    run_access(1'b1, 1'b0, 2, -1, 0, '0, lat, ex);
    check(lat == 5, "R4 wait low during count has no effect", lat, 5);
  endtask

  task automatic t_dma();
    int lat, ex;
    logic [15:0] d;
    write_reg(1'b0, 16'h0011);
    write_reg(1'b1, 16'h0026);
    #1;
    check(dram_cyc_o == 2'd2, "R6 dram_cyc from bits 5:4", int'(dram_cyc_o), 2);
    run_access(1'b0, 1'b1, 0, -1, 0, '0, lat, ex);
    check(lat == 6, "R5 dma space0 uses dma field", lat, 6);
    run_access(1'b1, 1'b1, 0, -1, 0, '0, lat, ex);
    check(lat == 6, "R5 dma space1 uses dma field", lat, 6);
    write_reg(1'b1, 16'hFFFF);
    read_reg(1'b1, d);
    check(d == 16'h003F, "R6 dma reserved bits zero", int'(d), 'h003F);
  endtask

  task automatic t_start_ignored();
    int lat, ex;
    write_reg(1'b0, 16'h0004);
    run_access(1'b0, 1'b0, 0, 1, 1, '0, lat, ex);
    check(lat == 4, "R8 start during access ignored, latency", lat, 4);
    check(ex == 0, "R8 start during access gives no second ready", ex, 0);
  endtask

  task automatic t_write_mid();
    int lat, ex;
    write_reg(1'b0, 16'h0006);
    run_access(1'b0, 1'b0, 0, 2, 2, 16'h0001, lat, ex);
    check(lat == 6, "R9 write mid-access keeps length", lat, 6);
    run_access(1'b0, 1'b0, 0, -1, 0, '0, lat, ex);
    check(lat == 1, "R9 new value at next start", lat, 1);
  endtask

  task automatic t_manual_reset();
    int lat, ex;
    logic [15:0] d;
    write_reg(1'b1, 16'h0015);
    write_reg(1'b0, 16'h000A);
    run_access(1'b0, 1'b0, 0, 2, 3, '0, lat, ex);
    check(lat == -1, "R7 manual reset aborts access", lat, -1);
    read_reg(1'b0, d);
    check(d == 16'h00FF, "R7 space reg restored", int'(d), 'h00FF);
    read_reg(1'b1, d);
    check(d == 16'h0015, "R7 dma reg kept", int'(d), 'h0015);
    run_access(1'b0, 1'b0, 0, -1, 0, '0, lat, ex);
    check(lat == 15, "R7 restored count applies", lat, 15);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_space_latency();
    t_zero_count();
    t_ext_wait();
    t_dma();
    t_start_ignored();
    t_write_mid();
    t_manual_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule